// File: doc/BRIEF.md
# Time-Slot Bandwidth Reservation Table

This block holds the time-slot schedule for one output port of a router in a network on chip. The link's capacity is cut into a fixed number of equal time slots. Each slot is either free or owned by a single virtual channel. A channel's guaranteed bandwidth is the number of slots it owns times the rate of one slot. For example, a ten-slot table on a 10 Gbps link can carry channels holding 1, 1, 2, 3 and 3 slots. A free-running slot pointer steps through the table once per cycle. All ports of the chip share one time base, so their pointers stay in lock-step. Each cycle the block reports which channel may drive the link, or reports that the slot is idle.

Path-setup logic writes the table through a single-cycle request port. A reserve request claims a set of slots, given as a bit mask, for one channel identifier. A release request frees the slots in a mask that belong to the named channel. A reserve that touches a slot held by another channel is refused in full. A channel that owns slot s here must own slot s+1 (modulo the table size) on the next link of its path. For that reason the block returns the next-hop mask of every accepted reservation. It also returns the next-hop index of the slot currently being served.

Top module: `tdm_slot_table`

## Requirements
- R1: After a synchronous active-low reset, every slot is free, the pointer `grant_slot` is 0, `free_count` equals the table size, `cfg_err` is 0 and `hop_mask` is 0.
- R2: `grant_slot` advances by one on every clock edge and wraps from table size minus one to 0.
- R3: While the current slot is free, `grant_valid` is 0 and `grant_vc` is 0. While the slot is owned, `grant_valid` is 1 and `grant_vc` gives the owning channel.
- R4: A reserve request (`cfg_valid`=1, `cfg_op`=0) that meets no conflict gives every slot whose bit is set in `cfg_mask` (bit i is slot i) to `cfg_vc`. The change shows on the outputs after the edge that samples the request.
- R5: A reserve request that names any slot owned by a different channel changes no slot. `cfg_err` is 1 for exactly the cycle after that edge, and 0 in every cycle that does not follow such a refusal.
- R6: A reserve that names slots already owned by the same channel is not a conflict. It is accepted together with its free slots.
- R7: A release request (`cfg_valid`=1, `cfg_op`=1) frees only the masked slots owned by `cfg_vc`. Slots of other channels stay as they are, even when their bits are set in the mask.
- R8: `free_count` always equals the number of free slots and follows the table in the same cycle the table changes.
- R9: `next_hop_slot` equals (`grant_slot` + 1) modulo the table size.
- R10: After an accepted reserve, `hop_mask` holds that request's mask rotated up by one position (bit i moves to bit i+1, and the top bit moves to bit 0). It keeps that value until the next accepted reserve.
- R11: While `cfg_valid` is 0, the table does not change, whatever `cfg_op`, `cfg_vc` and `cfg_mask` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all ports of the time base |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_valid | input | 1 | Request strobe, one request per cycle |
| cfg_op | input | 1 | 0 = reserve, 1 = release |
| cfg_vc | input | VC_W (3) | Channel identifier of the request |
| cfg_mask | input | NUM_SLOTS (10) | Slot set of the request, bit i = slot i |
| cfg_err | output | 1 | Pulse: previous reserve refused for conflict |
| hop_mask | output | NUM_SLOTS (10) | Next-hop slot set of the last accepted reserve |
| grant_valid | output | 1 | Current slot is owned |
| grant_vc | output | VC_W (3) | Owner of the current slot, 0 when idle |
| grant_slot | output | SLOT_W (4) | Index of the current slot |
| next_hop_slot | output | SLOT_W (4) | Slot index the same data uses on the next link |
| free_count | output | CNT_W (4) | Number of unowned slots |

## Verification
The hardest case to reach is a reserve whose mask covers both the requester's own slots and a slot owned by another channel. It must be refused in full, with none of its free slots taken. A second hard case is a release whose mask covers slots of other channels. The stimulus first fills the table completely with five channels of unequal size. From there it aims requests at exactly these overlaps. It then runs a long pseudo-random stream of sparse masks with random channels and operations. That stream keeps the table partly full, so conflicts, partial releases and self-overlaps keep recurring while the pointer passes over every slot.

// File: rtl/tdm_slot_pkg.sv
// Shared definitions for the time-slot reservation table.
// Assumes: one request per cycle on the configuration port.
package tdm_slot_pkg;
    typedef enum logic {
        OP_RESERVE = 1'b0,
        OP_RELEASE = 1'b1
    } cfg_op_e;
endpackage

// File: rtl/tdm_slot_counter.sv
// Free-running slot pointer. It steps once per cycle and wraps at NUM_SLOTS-1.
// It also gives the index the same data occupies on the next hop.
// Assumes: every port of the chip is reset together, which keeps the pointers in lock-step.
module tdm_slot_counter #(
    parameter int NUM_SLOTS = 10,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [SLOT_W-1:0] cur_slot,
    output logic [SLOT_W-1:0] nxt_slot
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0] ptr_q;

    // Advance the pointer, wrapping after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n)             ptr_q <= '0;
        else if (ptr_q == LAST) ptr_q <= '0;
        else                    ptr_q <= ptr_q + 1'b1;
    end

    // Next-hop index, modulo table size.
    always_comb begin
        nxt_slot = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end

    assign cur_slot = ptr_q;

    AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q == LAST) |=> (ptr_q == '0));                       // R2
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + 1'b1));      // R2
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q <= LAST));                                         // R2
endmodule

// File: rtl/tdm_slot_store.sv
// Slot ownership store. It holds a used bit and an owner identifier per slot.
// It checks each reserve for conflict, applies reserve or release,
// reports a refused reserve one cycle later, and keeps the next-hop mask of
// the last accepted reserve. A read port gives the owner of one slot.
// Assumes: the request inputs are stable around the clock edge.
module tdm_slot_store
    import tdm_slot_pkg::*;
#(
    parameter int NUM_SLOTS = 10,
    parameter int VC_W      = 3,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  cfg_op_e              req_op,
    input  logic [VC_W-1:0]      req_vc,
    input  logic [NUM_SLOTS-1:0] req_mask,
    input  logic [SLOT_W-1:0]    rd_slot,
    output logic                 rd_used,
    output logic [VC_W-1:0]      rd_vc,
    output logic [NUM_SLOTS-1:0] used_vec,
    output logic                 err_pulse,
    output logic [NUM_SLOTS-1:0] hop_q
);
    logic [VC_W-1:0]           own_q [NUM_SLOTS];
    logic [NUM_SLOTS-1:0]      used_q;
    logic [NUM_SLOTS-1:0]      clash;
    logic [NUM_SLOTS*VC_W-1:0] own_flat;
    logic                      do_res;
    logic                      do_rel;
    logic                      any_clash;
    logic                      accept;
    logic                      err_q;

    assign do_res    = req_valid && (req_op == OP_RESERVE);
    assign do_rel    = req_valid && (req_op == OP_RELEASE);
    assign any_clash = |clash;
    assign accept    = do_res && !any_clash;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        // Flag a slot that the request names but another channel holds.
        assign clash[i] = req_mask[i] && used_q[i] && (own_q[i] != req_vc);

        // Update one slot on an accepted reserve or a matching release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                used_q[i] <= 1'b0;
                own_q[i]  <= '0;
            end else if (accept && req_mask[i]) begin
                used_q[i] <= 1'b1;
                own_q[i]  <= req_vc;
            end else if (do_rel && req_mask[i] && used_q[i] && (own_q[i] == req_vc)) begin
                used_q[i] <= 1'b0;
            end
        end

        assign own_flat[i*VC_W +: VC_W] = own_q[i];
    end

    // Register the refusal flag for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= do_res && any_clash;
    end

    // Keep the mask to reserve on the next link, rotated up by one slot.
    always_ff @(posedge clk) begin
        if (!rst_n)      hop_q <= '0;
        else if (accept) hop_q <= {req_mask[NUM_SLOTS-2:0], req_mask[NUM_SLOTS-1]};
    end

    // Read the owner of the addressed slot.
    always_comb begin
        rd_used = 1'b0;
        rd_vc   = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            if (rd_slot == SLOT_W'(k)) begin
                rd_used = used_q[k];
                rd_vc   = own_q[k];
            end
        end
    end

    assign used_vec  = used_q;
    assign err_pulse = err_q;

    AST_REFUSE_KEEPS_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> ($stable(used_q) && $stable(own_flat)));                      // R5
    AST_ERR_FROM_RESERVE: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(req_valid && req_op == OP_RESERVE));                     // R5
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(used_q) && $stable(own_flat)));                  // R11
    AST_HOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_op == OP_RESERVE) |=> $stable(hop_q));                // R10
    AST_RELEASE_NO_GROW: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_RELEASE) |=> ((used_q & ~$past(used_q)) == '0)); // R7
endmodule

// File: rtl/tdm_free_count.sv
// Counts the free slots in the used vector. Purely combinational, so the
// count changes in the same cycle as the table.
// Assumes: CNT_W can hold NUM_SLOTS.
module tdm_free_count #(
    parameter int NUM_SLOTS = 10,
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic [NUM_SLOTS-1:0] used_vec,
    output logic [CNT_W-1:0]     free_cnt
);
    // Add up the clear bits.
    always_comb begin
        free_cnt = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            free_cnt = free_cnt + CNT_W'(!used_vec[i]);
        end
    end
endmodule

// File: rtl/tdm_slot_table.sv
// Top of the time-slot reservation table for one router output port.
// It ties the slot pointer, the ownership store and the free counter together
// and drives the per-cycle grant of the link.
// Assumes: one configuration request per cycle; all ports share clk and rst_n.
module tdm_slot_table
    import tdm_slot_pkg::*;
#(
    parameter int NUM_SLOTS = 10,
    parameter int VC_W      = 3,
    parameter int SLOT_W    = $clog2(NUM_SLOTS),
    parameter int CNT_W     = $clog2(NUM_SLOTS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_valid,
    input  logic                 cfg_op,
    input  logic [VC_W-1:0]      cfg_vc,
    input  logic [NUM_SLOTS-1:0] cfg_mask,
    output logic                 cfg_err,
    output logic [NUM_SLOTS-1:0] hop_mask,
    output logic                 grant_valid,
    output logic [VC_W-1:0]      grant_vc,
    output logic [SLOT_W-1:0]    grant_slot,
    output logic [SLOT_W-1:0]    next_hop_slot,
    output logic [CNT_W-1:0]     free_count
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(NUM_SLOTS - 1);

    logic [SLOT_W-1:0]    cur_slot;
    logic [SLOT_W-1:0]    nxt_slot;
    logic                 rd_used;
    logic [VC_W-1:0]      rd_vc;
    logic [NUM_SLOTS-1:0] used_vec;
    cfg_op_e              op_e;

    assign op_e = cfg_op_e'(cfg_op);

    tdm_slot_counter #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cur_slot (cur_slot),
        .nxt_slot (nxt_slot)
    );

    tdm_slot_store #(.NUM_SLOTS(NUM_SLOTS), .VC_W(VC_W), .SLOT_W(SLOT_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (cfg_valid),
        .req_op    (op_e),
        .req_vc    (cfg_vc),
        .req_mask  (cfg_mask),
        .rd_slot   (cur_slot),
        .rd_used   (rd_used),
        .rd_vc     (rd_vc),
        .used_vec  (used_vec),
        .err_pulse (cfg_err),
        .hop_q     (hop_mask)
    );

    tdm_free_count #(.NUM_SLOTS(NUM_SLOTS), .CNT_W(CNT_W)) u_free (
        .used_vec (used_vec),
        .free_cnt (free_count)
    );

    // Grant the current slot to its owner, or mark it idle.
    always_comb begin
        grant_valid = rd_used;
        grant_vc    = rd_used ? rd_vc : '0;
    end

    assign grant_slot    = cur_slot;
    assign next_hop_slot = nxt_slot;

    AST_IDLE_VC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (grant_vc == '0));                                   // R3
    AST_GRANT_IMPLIES_USED: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> (free_count < CNT_W'(NUM_SLOTS)));                    // R8
    AST_IDLE_IMPLIES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_valid |-> (free_count != '0));                                 // R8
    AST_NEXT_HOP: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_slot == LAST) ? (next_hop_slot == '0)
                             : (next_hop_slot == grant_slot + 1'b1));         // R9
endmodule

// File: tb/tb_tdm_slot_table.sv
module tb_tdm_slot_table;
    localparam int N      = 10;
    localparam int VC_W   = 3;
    localparam int SLOT_W = $clog2(N);
    localparam int CNT_W  = $clog2(N + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_valid = 1'b0;
    logic              cfg_op = 1'b0;
    logic [VC_W-1:0]   cfg_vc = '0;
    logic [N-1:0]      cfg_mask = '0;
    logic              cfg_err;
    logic [N-1:0]      hop_mask;
    logic              grant_valid;
    logic [VC_W-1:0]   grant_vc;
    logic [SLOT_W-1:0] grant_slot;
    logic [SLOT_W-1:0] next_hop_slot;
    logic [CNT_W-1:0]  free_count;

    int  checks = 0;
    int  errors = 0;
    bit  cmp_en = 0;
    bit  done   = 0;

    // Reference model state
    int       own_m  [N];
    bit       used_m [N];
    int       slot_m;
    bit       err_m;
    bit [N-1:0] hop_m;

    always #4 clk = ~clk;

    tdm_slot_table #(.NUM_SLOTS(N), .VC_W(VC_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_op(cfg_op),
        .cfg_vc(cfg_vc), .cfg_mask(cfg_mask), .cfg_err(cfg_err),
        .hop_mask(hop_mask), .grant_valid(grant_valid), .grant_vc(grant_vc),
        .grant_slot(grant_slot), .next_hop_slot(next_hop_slot),
        .free_count(free_count)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int free_m();
        int f = 0;
        for (int i = 0; i < N; i++) if (!used_m[i]) f++;
        return f;
    endfunction

    // Behavioural model of the table, stepped on each clock edge
    always @(posedge clk) begin
        bit clash;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin used_m[i] = 0; own_m[i] = 0; end
            slot_m = 0; err_m = 0; hop_m = '0;
        end else begin
            slot_m = (slot_m + 1) % N;
            err_m  = 0;
            if (cfg_valid && cfg_op == 1'b0) begin
                clash = 0;
                for (int i = 0; i < N; i++)
                    if (cfg_mask[i] && used_m[i] && own_m[i] != int'(cfg_vc)) clash = 1;
                if (clash) err_m = 1;
                else begin
                    for (int i = 0; i < N; i++)
                        if (cfg_mask[i]) begin used_m[i] = 1; own_m[i] = int'(cfg_vc); end
                    hop_m = '0;
                    for (int i = 0; i < N; i++) hop_m[(i + 1) % N] = cfg_mask[i];
                end
            end else if (cfg_valid && cfg_op == 1'b1) begin
                for (int i = 0; i < N; i++)
                    if (cfg_mask[i] && used_m[i] && own_m[i] == int'(cfg_vc)) used_m[i] = 0;
            end
        end
    end

    // Compare every output against the model away from the active edge
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(int'(grant_slot) == slot_m, "R2 grant_slot", int'(grant_slot), slot_m);
            chk(int'(next_hop_slot) == (slot_m + 1) % N, "R9 next_hop_slot",
                int'(next_hop_slot), (slot_m + 1) % N);
            chk(grant_valid == used_m[slot_m], "R3 grant_valid", int'(grant_valid), int'(used_m[slot_m]));
            chk(int'(grant_vc) == (used_m[slot_m] ? own_m[slot_m] : 0), "R3 grant_vc",
                int'(grant_vc), used_m[slot_m] ? own_m[slot_m] : 0);
            chk(int'(free_count) == free_m(), "R8 free_count", int'(free_count), free_m());
            chk(cfg_err == err_m, "R5 cfg_err", int'(cfg_err), int'(err_m));
            chk(hop_mask == hop_m, "R10 hop_mask", int'(hop_mask), int'(hop_m));
        end
    end

    task automatic req(input bit op, input int vc, input logic [N-1:0] m);
        @(negedge clk);
        cfg_valid = 1'b1; cfg_op = op; cfg_vc = VC_W'(vc); cfg_mask = m;
        @(negedge clk);
        cfg_valid = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        logic [N-1:0] m1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk(grant_slot == '0, "R1 slot", int'(grant_slot), 0);
        chk(int'(free_count) == N, "R1 free", int'(free_count), N);
        chk(!grant_valid && !cfg_err && hop_mask == '0, "R1 flags",
            int'({grant_valid, cfg_err}), 0);
        rst_n = 1'b1;
        cmp_en = 1;

        // R4: fill the table with channels of 1,1,2,3,3 slots
        req(0, 1, 10'b0000000001);
        req(0, 2, 10'b0000000010);
        req(0, 3, 10'b0000001100);
        req(0, 4, 10'b0001110000);
        req(0, 5, 10'b1110000000);
        chk(int'(free_count) == 0, "R4 full table", int'(free_count), 0);
        chk(hop_mask == 10'b1100000001, "R10 wrap rotate", int'(hop_mask), 10'b1100000001);
        repeat (12) @(negedge clk);

        // R5: conflicting reserve by channel 6, with a free slot included nowhere
        req(0, 6, 10'b0000100000);
        chk(int'(free_count) == 0, "R5 table unchanged", int'(free_count), 0);
        // R6: channel 4 re-reserves its own slot 4
        req(0, 4, 10'b0000010000);
        chk(cfg_err == 1'b0, "R6 no error on own slot", int'(cfg_err), 0);
        // R7: release of channel 3 with full mask frees only its two slots
        req(1, 3, 10'b1111111111);
        chk(int'(free_count) == 2, "R7 release own only", int'(free_count), 2);
        // R7: channel 4 names slot 7 owned by channel 5: no effect
        req(1, 4, 10'b0010000000);
        chk(int'(free_count) == 2, "R7 foreign slot kept", int'(free_count), 2);
        // R5: mixed reserve, free slot 2 plus foreign slot 0, refused entirely
        req(0, 4, 10'b0000000101);
        chk(int'(free_count) == 2, "R5 partial refused", int'(free_count), 2);
        // R11: idle inputs carrying a release-all pattern
        @(negedge clk);
        cfg_valid = 1'b0; cfg_op = 1'b1; cfg_vc = 3'd5; cfg_mask = '1;
        repeat (5) @(negedge clk);
        chk(int'(free_count) == 2, "R11 idle ignored", int'(free_count), 2);
        // back-to-back requests
        @(negedge clk);
        cfg_valid = 1'b1; cfg_op = 1'b0; cfg_vc = 3'd7; cfg_mask = 10'b0000001100;
        @(negedge clk);
        cfg_vc = 3'd6; cfg_mask = 10'b0000000100;
        @(negedge clk);
        cfg_valid = 1'b0;
        chk(int'(free_count) == 0, "R4 back-to-back", int'(free_count), 0);
        for (int v = 0; v < 8; v++) req(1, v, '1);
        chk(int'(free_count) == N, "R7 all released", int'(free_count), N);

        // Pseudo-random stream
        for (int n = 0; n < 3000; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            m1   = lfsr[9:0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            @(negedge clk);
            cfg_valid = lfsr[0] | lfsr[1];
            cfg_op    = lfsr[2] & lfsr[3];
            cfg_vc    = lfsr[6:4];
            cfg_mask  = m1 & lfsr[15:6];
        end
        @(negedge clk);
        cfg_valid = 1'b0;
        repeat (N + 2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule